// File: doc/BRIEF.md
# Indirect Peripheral Clock Configuration Register Block

This block keeps a small clock setting for each of a parameterised number of peripherals: a generated-clock enable bit, a clock source select field and an 8-bit divider field. Software reaches all of these through one shared 32-bit control word. Every write carries a peripheral identifier. A command bit in the same word decides what the write does. With the bit clear, the write only points the block at a peripheral. With the bit set, the write also loads that peripheral's settings from the write data.

Reads return the settings of the peripheral picked by the last write, together with its identifier. All peripherals' settings leave the block in parallel on registered outputs, ready for the clock generators that use them. Each write is decoded into one of three named access kinds: ACC_IDLE (no write), ACC_SELECT (write with the command bit clear) and ACC_COMMIT (write with the command bit set). The latched identifier moves only on ACC_SELECT and ACC_COMMIT. An entry is loaded only on ACC_COMMIT when the identifier names a peripheral that exists.

Control word bit positions, used for both writes and reads: identifier in bits [5:0]; source select in bits [10:8]; command bit at bit 12; divider in bits [27:20]; enable at bit 28. All other bits are unused.

Top module: `pclk_cfg_regs`

## Requirements
- R1: After reset, every entry holds enable 0, source 0 and divider 0, the latched identifier is 0, and `rdata` is 0.
- R2: A write with bit 12 clear latches identifier bits [5:0] and leaves every entry and every configuration output unchanged, whatever the other data bits hold.
- R3: When `rd_en` is high at a clock edge, `rdata` takes, from that edge on, the latched identifier in bits [5:0], the selected entry's source in [10:8], divider in [27:20] and enable at bit 28. `rdata` holds its value at edges where `rd_en` is low.
- R4: A write with bit 12 set latches identifier bits [5:0] and loads that entry's enable from bit 28, source from [10:8] and divider from [27:20].
- R5: The divider field stores any 8-bit value 0 to 255 unchanged. The value is the division ratio minus one, so ratios 1 to 256 are covered.
- R6: A committed write with bit 28 clear turns that peripheral's `cfg_en` bit off.
- R7: Only bits [5:0] form the identifier. Bits 7 and 6 of the write data have no effect on selection or commit.
- R8: An identifier at or above NUM_PERIPH selects nothing. A read then returns zeros in the enable, source and divider fields. A committed write to it changes no output.
- R9: Bit 12 and every unused bit of `rdata` always read as zero.
- R10: Configuration outputs are registered. They change only at the clock edge that takes a commit, and only for the committed entry.
- R11: When a read and a write arrive at the same edge, the read returns the selection and entry contents held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe; loads rdata at this edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (registered) |
| cfg_en | output | NUM_PERIPH | Generated-clock enable per peripheral |
| cfg_src | output | NUM_PERIPH*SRC_W | Source select per peripheral, entry i at [i*SRC_W +: SRC_W] |
| cfg_div | output | NUM_PERIPH*DIV_W | Divider per peripheral, entry i at [i*DIV_W +: DIV_W] |

## Verification
Directed sequences come first. A select write carries junk in its settings bits, to show it loads nothing. A commit writes a full-scale divider. A later commit clears the enable. Identifiers carry set bits 7 and 6 to show the masking. An identifier beyond the peripheral count shows that read zeroing and commit suppression both work. A combined read and write at one edge separates read-before-write from read-after-write ordering. A seeded random mix of selects, commits and reads, with identifiers spread across both the valid and invalid range, then checks that entries stay isolated from one another and that read-back tracks the latched selection.

// File: rtl/pclk_cfg_pkg.sv
package pclk_cfg_pkg;
    localparam int DATA_W  = 32;
    localparam int ID_LSB  = 0;
    localparam int SRC_LSB = 8;
    localparam int CMD_BIT = 12;
    localparam int DIV_LSB = 20;
    localparam int EN_BIT  = 28;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_SELECT = 2'd1,
        ACC_COMMIT = 2'd2
    } acc_e;
endpackage

// File: rtl/pclk_cfg_decode.sv
module pclk_cfg_decode
    import pclk_cfg_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 6,
    parameter int SRC_W      = 3,
    parameter int DIV_W      = 8
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output acc_e              acc,
    output logic [ID_W-1:0]   f_id,
    output logic              f_en,
    output logic [SRC_W-1:0]  f_src,
    output logic [DIV_W-1:0]  f_div,
    output logic              f_hit
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        unique case ({wr_en, wdata[CMD_BIT]})
            2'b10:   acc = ACC_SELECT;
            2'b11:   acc = ACC_COMMIT;
            default: acc = ACC_IDLE;
        endcase
    end

    assign f_id  = wdata[ID_LSB +: ID_W];
    assign f_en  = wdata[EN_BIT];
    assign f_src = wdata[SRC_LSB +: SRC_W];
    assign f_div = wdata[DIV_LSB +: DIV_W];
    assign f_hit = (int'(f_id) < NUM_PERIPH);
endmodule

// File: rtl/pclk_cfg_bank.sv
module pclk_cfg_bank #(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 6,
    parameter int SRC_W      = 3,
    parameter int DIV_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [ID_W-1:0]             c_id,
    input  logic                        c_en,
    input  logic [SRC_W-1:0]            c_src,
    input  logic [DIV_W-1:0]            c_div,
    output logic [NUM_PERIPH-1:0]       cfg_en,
    output logic [NUM_PERIPH*SRC_W-1:0] cfg_src,
    output logic [NUM_PERIPH*DIV_W-1:0] cfg_div
);
    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_entry
        logic hit;
        assign hit = commit && (int'(c_id) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_en[g]                   <= 1'b0;
                cfg_src[g*SRC_W +: SRC_W]   <= '0;
                cfg_div[g*DIV_W +: DIV_W]   <= '0;
            end else if (hit) begin
                cfg_en[g]                   <= c_en;
                cfg_src[g*SRC_W +: SRC_W]   <= c_src;
                cfg_div[g*DIV_W +: DIV_W]   <= c_div;
            end
        end
    end
endmodule

// File: rtl/pclk_cfg_rdmux.sv
module pclk_cfg_rdmux
    import pclk_cfg_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 6,
    parameter int SRC_W      = 3,
    parameter int DIV_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [ID_W-1:0]             sel_id,
    input  logic [NUM_PERIPH-1:0]       cfg_en,
    input  logic [NUM_PERIPH*SRC_W-1:0] cfg_src,
    input  logic [NUM_PERIPH*DIV_W-1:0] cfg_div,
    output logic [DATA_W-1:0]           rdata
);
    logic             s_en;
    logic [SRC_W-1:0] s_src;
    logic [DIV_W-1:0] s_div;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        s_en  = 1'b0;
        s_src = '0;
        s_div = '0;
        for (int i = 0; i < NUM_PERIPH; i++) begin
            if (int'(sel_id) == i) begin
                s_en  = cfg_en[i];
                s_src = cfg_src[i*SRC_W +: SRC_W];
                s_div = cfg_div[i*DIV_W +: DIV_W];
            end
        end
        rd_next                      = '0;
        rd_next[ID_LSB +: ID_W]      = sel_id;
        rd_next[SRC_LSB +: SRC_W]    = s_src;
        rd_next[DIV_LSB +: DIV_W]    = s_div;
        rd_next[EN_BIT]              = s_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/pclk_cfg_regs.sv
module pclk_cfg_regs
    import pclk_cfg_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 6,
    parameter int SRC_W      = 3,
    parameter int DIV_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    output logic [NUM_PERIPH-1:0]       cfg_en,
    output logic [NUM_PERIPH*SRC_W-1:0] cfg_src,
    output logic [NUM_PERIPH*DIV_W-1:0] cfg_div
);
    acc_e             acc;
    logic [ID_W-1:0]  f_id;
    logic             f_en;
    logic [SRC_W-1:0] f_src;
    logic [DIV_W-1:0] f_div;
    logic             f_hit;
    logic [ID_W-1:0]  sel_q;
    logic             commit;

    pclk_cfg_decode #(
        .NUM_PERIPH(NUM_PERIPH), .ID_W(ID_W), .SRC_W(SRC_W), .DIV_W(DIV_W)
    ) u_decode (
        .wr_en(wr_en), .wdata(wdata), .acc(acc), .f_id(f_id),
        .f_en(f_en), .f_src(f_src), .f_div(f_div), .f_hit(f_hit)
    );

    // Selection register: moves on both write kinds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            unique case (acc)
                ACC_SELECT, ACC_COMMIT: sel_q <= f_id;
                ACC_IDLE:               sel_q <= sel_q;
                default:                sel_q <= sel_q;
            endcase
        end
    end

    assign commit = (acc == ACC_COMMIT) && f_hit;

    pclk_cfg_bank #(
        .NUM_PERIPH(NUM_PERIPH), .ID_W(ID_W), .SRC_W(SRC_W), .DIV_W(DIV_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .commit(commit), .c_id(f_id),
        .c_en(f_en), .c_src(f_src), .c_div(f_div),
        .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_div(cfg_div)
    );

    pclk_cfg_rdmux #(
        .NUM_PERIPH(NUM_PERIPH), .ID_W(ID_W), .SRC_W(SRC_W), .DIV_W(DIV_W)
    ) u_rdmux (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel_id(sel_q),
        .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_div(cfg_div), .rdata(rdata)
    );
endmodule

// File: rtl/pclk_cfg_chk.sv
module pclk_cfg_chk
    import pclk_cfg_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int ID_W       = 6,
    parameter int SRC_W      = 3,
    parameter int DIV_W      = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [31:0]                 wdata,
    input logic [31:0]                 rdata,
    input logic [NUM_PERIPH-1:0]       cfg_en,
    input logic [NUM_PERIPH*SRC_W-1:0] cfg_src,
    input logic [NUM_PERIPH*DIV_W-1:0] cfg_div
);
    localparam logic [31:0] USED_MASK =
        (((32'd1 << ID_W) - 32'd1) << ID_LSB) |
        (((32'd1 << SRC_W) - 32'd1) << SRC_LSB) |
        (((32'd1 << DIV_W) - 32'd1) << DIV_LSB) |
        (32'd1 << EN_BIT);

    logic good_commit;
    assign good_commit = wr_en && wdata[CMD_BIT] && (int'(wdata[ID_W-1:0]) < NUM_PERIPH);

    p_select_keeps_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[CMD_BIT]) |=> ($stable(cfg_en) && $stable(cfg_src) && $stable(cfg_div)));

    p_rdata_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    p_commit_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        good_commit |=> (cfg_en[$past(wdata[ID_W-1:0])] == $past(wdata[EN_BIT])));

    p_commit_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        good_commit |=> (cfg_div[$past(wdata[ID_W-1:0])*DIV_W +: DIV_W] == $past(wdata[DIV_LSB +: DIV_W])));

    p_oor_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[CMD_BIT] && (int'(wdata[ID_W-1:0]) >= NUM_PERIPH))
        |=> ($stable(cfg_en) && $stable(cfg_src) && $stable(cfg_div)));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~USED_MASK) == 32'd0);

    p_no_write_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cfg_en) && $stable(cfg_src) && $stable(cfg_div)));
endmodule

bind pclk_cfg_regs pclk_cfg_chk #(
    .NUM_PERIPH(NUM_PERIPH), .ID_W(ID_W), .SRC_W(SRC_W), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_div(cfg_div)
);

// File: tb/pclk_cfg_regs_bench.sv
`timescale 1ns/1ps
module pclk_cfg_regs_bench;
    localparam int NP = 8;
    localparam int SW = 3;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0]    cfg_en;
    logic [NP*SW-1:0] cfg_src;
    logic [NP*DW-1:0] cfg_div;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit       m_en  [NP];
    bit [2:0] m_src [NP];
    bit [7:0] m_div [NP];
    bit [5:0] m_sel;
    logic [31:0] exp_r;

    always #10 clk = ~clk;

    pclk_cfg_regs #(.NUM_PERIPH(NP), .ID_W(6), .SRC_W(SW), .DIV_W(DW)) u_pclk_cfg_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_div(cfg_div)
    );

    function automatic logic [31:0] word(bit en, bit [7:0] dv, bit [2:0] src, bit cmd, bit [7:0] id);
        logic [31:0] w;
        w = '0;
        w[7:0] = id; w[10:8] = src; w[12] = cmd; w[27:20] = dv; w[28] = en;
        return w;
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] w;
        w = '0;
        w[5:0] = m_sel;
        if (int'(m_sel) < NP) begin
            w[10:8] = m_src[m_sel]; w[27:20] = m_div[m_sel]; w[28] = m_en[m_sel];
        end
        return w;
    endfunction

    task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_cfg(string req);
        logic [NP-1:0] e; logic [NP*SW-1:0] s; logic [NP*DW-1:0] d;
        for (int i = 0; i < NP; i++) begin
            e[i] = m_en[i]; s[i*SW +: SW] = m_src[i]; d[i*DW +: DW] = m_div[i];
        end
        check_eq({req, " cfg_en"},  64'(cfg_en),  64'(e));
        check_eq({req, " cfg_src"}, 64'(cfg_src), 64'(s));
        check_eq({req, " cfg_div"}, 64'(cfg_div), 64'(d));
    endtask

    // One access, then an idle edge; checks registered timing of outputs
    task automatic op(logic [31:0] w, bit wr, bit rd, string req);
        @(negedge clk);
        wr_en = wr; rd_en = rd; wdata = w;
        if (rd) exp_r = exp_read();
        #1 check_cfg({req, "/R10 before edge"});
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
        if (wr) begin
            m_sel = w[5:0];
            if (w[12] && int'(w[5:0]) < NP) begin
                m_en[w[5:0]] = w[28]; m_src[w[5:0]] = w[10:8]; m_div[w[5:0]] = w[27:20];
            end
        end
        @(negedge clk);
        check_cfg(req);
        check_eq({req, " rdata"}, 64'(rdata), 64'(exp_r));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        for (int i = 0; i < NP; i++) begin m_en[i] = 0; m_src[i] = 0; m_div[i] = 0; end
        m_sel = 0; exp_r = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_cfg("R1 reset");
        check_eq("R1 rdata reset", 64'(rdata), 64'd0);
        rst_n = 1'b1;

        op(32'd0, 0, 1, "R1 read id0");
        op(word(1, 8'hFF, 3'd5, 1, 8'd3), 1, 0, "R4 R5 commit id3 div255");
        op(32'd0, 0, 1, "R3 read id3");
        check_eq("R9 cmd bit reads zero", 64'(rdata[12]), 64'd0);
        op(word(1, 8'hA5, 3'd7, 0, 8'd5) | 32'hE00F_E0C0, 1, 0, "R2 select junk");
        op(32'd0, 0, 1, "R2 read id5");
        op(word(0, 8'h00, 3'd2, 1, 8'd3), 1, 0, "R6 clear enable");
        check_eq("R6 cfg_en[3] off", 64'(cfg_en[3]), 64'd0);
        op(word(1, 8'h12, 3'd6, 1, 8'hC2), 1, 0, "R7 masked id commit");
        op(32'd0, 0, 1, "R7 read masked id");
        check_eq("R7 id field", 64'(rdata[7:0]), 64'd2);
        op(word(1, 8'h77, 3'd1, 1, 8'd9), 1, 0, "R8 oor commit");
        op(32'd0, 0, 1, "R8 oor read");
        op(word(1, 8'h00, 3'd4, 1, 8'd7), 1, 1, "R11 read+write");
        op(32'd0, 0, 0, "R3 rdata hold");
        op(32'd0, 0, 1, "R11 read after");

        for (int k = 0; k < 400; k++) begin
            w = $urandom;
            w[5:0] = 6'($urandom_range(0, 11));
            op(w, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R3 R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule